// File: doc/BRIEF.md
# Serial Configuration ROM Model

This block stands in for a one-bit-wide configuration memory that a loader reads one bit at a time. The loader supplies the clock, an active-low chip enable and a single control pin that clears the read position and disables the output. The polarity of that control pin is fixed by a parameter. The block keeps an internal read address. It presents the bit stored at that address on a data output, together with an enable flag that stands for the output driver of a tri-state pin. It also reports which of three supply-current states the memory is in.

The stored contents are computed, not loaded. Each bit is the XOR-reduction of the address masked by a parameter, inverted by a second parameter. This keeps the block synthesizable at any depth without a memory array. The address moves forward one step on each qualifying clock edge. It stops at the last location and does not wrap. The output bit is combinational from the address register. It therefore settles shortly after the edge that moved the address, and the loader takes it on its following rising edge.

Top module: `cfgrom_serial_model`

## Requirements
- R1: With `ce_n` low and the control pin inactive, each rising clock edge advances the address by exactly one, and the bit at the new address is on `data_o` after that edge.
- R2: While the control pin is active, every rising edge sets the address to zero. `data_oe` and `data_o` read 0 for as long as the pin is active, with no clock edge needed.
- R3: With `RESET_ACTIVE_HIGH` = 1 (the default), the control pin is active when high. With 0, it is active when low. Behaviour is otherwise identical.
- R4: While `ce_n` is high, `data_oe` is 0 whatever the level of the control pin.
- R5: While `ce_n` is high and the control pin is inactive, the address keeps its value. Once `ce_n` returns low, reading resumes from the next address.
- R6: While `ce_n` is high and the control pin is active, rising edges still set the address to zero.
- R7: The address never exceeds `DEPTH`-1. Once there, further qualifying edges leave it there and `data_o` keeps the last bit.
- R8: The bit at address a is the XOR of all bits of (a AND `CONTENT_MASK`), XORed with `CONTENT_INV` (defaults 32'h0003_1D6B and 1). `data_o` is 0 whenever `data_oe` is 0.
- R9: `pwr_state` is 2'b00 (active) when `ce_n` is low and the pin is inactive. It is 2'b01 (reduced) when `ce_n` is low and the pin is active. It is 2'b10 (standby) when `ce_n` is high. It never reads 2'b11.
- R10: `rst_n` low at a rising edge sets the address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock from the loader |
| rst_n | input | 1 | Synchronous active-low power-on clear of the address |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| ctl_pin | input | 1 | Combined address clear / output disable, polarity set by parameter |
| data_o | output | 1 | Stored bit at the current address, 0 when not driven |
| data_oe | output | 1 | High when the data pin would be driven |
| pwr_state | output | 2 | Supply-current state: 00 active, 01 reduced, 10 standby |

## Verification
The hardest case to reach is saturation at the last address. At the default depth it would take hundreds of thousands of edges, so the bench builds the block with a depth of 40 and runs past the end. It then checks that the address holds while the clock keeps running. A second hard case is an address freeze in standby that is followed by a clear while still in standby. The bench reaches it by toggling the chip enable and the control pin in separate phases and checking where reading resumes. A second instance built with the opposite polarity gets the inverted control pin on every cycle. It must match the same expected stream.

// File: rtl/cfgrom_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial configuration ROM model.
// Assumes: nothing beyond standard SystemVerilog packages.
package cfgrom_pkg;

    // Supply-current state as reported on the status port
    typedef enum logic [1:0] {
        PWR_ACTIVE  = 2'b00,
        PWR_REDUCED = 2'b01,
        PWR_STANDBY = 2'b10
    } pwr_state_e;

endpackage

// File: rtl/cfgrom_pin_decode.sv
`timescale 1ns/1ps
// Decodes the chip enable and the polarity-programmable control pin into
// address clear, address advance, output drive and supply-state status.
// Assumes: inputs are already synchronous to the read clock.
module cfgrom_pin_decode
    import cfgrom_pkg::*;
#(
    parameter bit RESET_ACTIVE_HIGH = 1'b1
) (
    input  logic       ctl_pin,
    input  logic       ce_n,
    output logic       clr,
    output logic       adv,
    output logic       drive,
    output pwr_state_e pwr
);

    logic pin_act;

    // Polarity selection of the combined control pin
    generate
        if (RESET_ACTIVE_HIGH) begin : g_pol_high
            assign pin_act = ctl_pin;
        end else begin : g_pol_low
            assign pin_act = ~ctl_pin;
        end
    endgenerate

    // Control strobes and supply-state selection
    always_comb begin
        clr   = pin_act;
        adv   = !ce_n && !pin_act;
        drive = !ce_n && !pin_act;
        if (ce_n)         pwr = PWR_STANDBY;
        else if (pin_act) pwr = PWR_REDUCED;
        else              pwr = PWR_ACTIVE;
    end

endmodule

// File: rtl/cfgrom_addr_ctr.sv
`timescale 1ns/1ps
// Saturating read-address counter: clears on rst_n or clr, steps on adv,
// holds at the last location.
// Assumes: DEPTH >= 2; clr has priority over adv.
module cfgrom_addr_ctr #(
    parameter int DEPTH = 336768,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Address register with clear priority and saturation at LAST
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr <= '0;
        end else if (adv && (addr != LAST)) begin
            addr <= addr + 1'b1;
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && addr != LAST) |=> (addr == $past(addr) + 1'b1)); // R1
    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(addr)); // R5
    AST_ADDR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == LAST && !clr) |=> (addr == LAST)); // R7
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST); // R7

endmodule

// File: rtl/cfgrom_bit_src.sv
`timescale 1ns/1ps
// Computed content source: bit = XOR-reduce(addr & MASK) ^ INV.
// Assumes: only the low AW bits of MASK are meaningful.
module cfgrom_bit_src #(
    parameter int          AW   = 19,
    parameter logic [31:0] MASK = 32'h0003_1D6B,
    parameter bit          INV  = 1'b1
) (
    input  logic [AW-1:0] addr,
    output logic          bit_o
);

    logic [AW-1:0] masked;

    // Per-bit masking of the address
    generate
        for (genvar i = 0; i < AW; i++) begin : g_mask
            assign masked[i] = addr[i] & MASK[i];
        end
    endgenerate

    // Parity reduction and inversion
    assign bit_o = (^masked) ^ INV;

endmodule

// File: rtl/cfgrom_serial_model.sv
`timescale 1ns/1ps
// Top of the serial configuration ROM model: one bit per qualifying clock
// edge from a computed content function, with standby and clear control.
// Assumes: the loader samples data_o on the rising edge after the one that
// moved the address.
module cfgrom_serial_model
    import cfgrom_pkg::*;
#(
    parameter int          DEPTH             = 336768,
    parameter bit          RESET_ACTIVE_HIGH = 1'b1,
    parameter logic [31:0] CONTENT_MASK      = 32'h0003_1D6B,
    parameter bit          CONTENT_INV       = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       ctl_pin,
    output logic       data_o,
    output logic       data_oe,
    output logic [1:0] pwr_state
);

    localparam int AW = $clog2(DEPTH);

    logic          clr;
    logic          adv;
    logic          drive;
    pwr_state_e    pwr;
    logic [AW-1:0] addr;
    logic          cur_bit;

    cfgrom_pin_decode #(
        .RESET_ACTIVE_HIGH(RESET_ACTIVE_HIGH)
    ) u_decode (
        .ctl_pin(ctl_pin),
        .ce_n   (ce_n),
        .clr    (clr),
        .adv    (adv),
        .drive  (drive),
        .pwr    (pwr)
    );

    cfgrom_addr_ctr #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .adv  (adv),
        .addr (addr)
    );

    cfgrom_bit_src #(
        .AW  (AW),
        .MASK(CONTENT_MASK),
        .INV (CONTENT_INV)
    ) u_bits (
        .addr (addr),
        .bit_o(cur_bit)
    );

    // Output stage: drive flag, gated data bit and status
    always_comb begin
        data_oe   = drive;
        data_o    = drive & cur_bit;
        pwr_state = pwr;
    end

    AST_OE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !data_oe); // R4
    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> !data_o); // R8
    AST_PWR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'b11); // R9
    AST_OE_MATCHES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (pwr_state == 2'b00)); // R9

endmodule

// File: tb/test_cfgrom_serial_model.sv
`timescale 1ns/1ps
module test_cfgrom_serial_model;

    localparam int TB_DEPTH = 40;
    localparam logic [31:0] TB_MASK = 32'h0003_1D6B;

    typedef struct {
        logic       oe;
        logic       d;
        logic [1:0] pw;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0;
    logic pin_hi = 1'b0;
    logic pin_lo;
    logic d_hi, oe_hi, d_lo, oe_lo;
    logic [1:0] pw_hi, pw_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];
    int model_addr = 0;

    assign pin_lo = ~pin_hi;

    always #2.5 clk = ~clk;

    cfgrom_serial_model #(.DEPTH(TB_DEPTH), .RESET_ACTIVE_HIGH(1'b1)) i_cfgrom_serial_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ctl_pin(pin_hi),
        .data_o(d_hi), .data_oe(oe_hi), .pwr_state(pw_hi));

    cfgrom_serial_model #(.DEPTH(TB_DEPTH), .RESET_ACTIVE_HIGH(1'b0)) i_cfgrom_serial_model_lo (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ctl_pin(pin_lo),
        .data_o(d_lo), .data_oe(oe_lo), .pwr_state(pw_lo));

    function automatic logic ref_bit(int a);
        return (($countones(32'(a) & TB_MASK) % 2) == 1) ^ 1'b1;
    endfunction

    // Driver: apply one cycle of stimulus, advance the model, push expectation
    task automatic step(input logic rn, input logic ce, input logic pin, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        rst_n = rn; ce_n = ce; pin_hi = pin;
        @(posedge clk);
        if (!rn || pin) model_addr = 0;
        else if (!ce && model_addr < TB_DEPTH - 1) model_addr = model_addr + 1;
        e.oe  = !ce && !pin;
        e.d   = e.oe ? ref_bit(model_addr) : 1'b0;
        e.pw  = ce ? 2'b10 : (pin ? 2'b01 : 2'b00);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic compare(input string who, input exp_t e, input logic oe, input logic d, input logic [1:0] pw);
        checks++;
        if (oe !== e.oe || d !== e.d || pw !== e.pw) begin
            errors++;
            $display("FAIL %s %s: oe/data/pwr = %b/%b/%b expected %b/%b/%b",
                     e.tag, who, oe, d, pw, e.oe, e.d, e.pw);
        end
    endtask

    // Monitor: pop expectations and compare both instances away from the edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compare("hi", e, oe_hi, d_hi, pw_hi);
            compare("lo(R3)", e, oe_lo, d_lo, pw_lo);
        end
    end

    initial begin
        // R10: power-on clear with rst_n low
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R10");
        // R1 R8: sequential reading
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, "R1_R8");
        // R4 R5 R9: standby freezes the address
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R4_R5_R9");
        // R5: resume from the next address
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R5");
        // R2 R9: control pin active clears, reduced state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R2_R9");
        // R7: run past the last location
        for (int i = 0; i < 45; i++) step(1'b1, 1'b0, 1'b0, "R7");
        // R4 R6: standby with the pin active still clears
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b1, "R4_R6");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R6");
        // R8: mixed pattern
        step(1'b1, 1'b0, 1'b1, "R2");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, "R8");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule